// File: doc/BRIEF.md
# I2C Master Serial Clock Generator

This block derives the serial clock of an I2C master from the source clock. A 16-bit divider word holds two 8-bit fields. The upper byte sets the length of the high phase and the lower byte sets the length of the low phase. Each phase is two source cycles longer than its field value. The block does not drive the line high. It asserts an open-drain pull-down enable for the low phase and releases the line for the high phase. While the line is released, the high-phase count advances only in cycles where the sampled line is seen high. A slave that holds the clock low therefore stretches the high phase.

The surrounding master logic enables the block, loads the divider word and pulses a start request to launch the clock. It uses three single-cycle strobes:
- a falling-edge strobe, when the line is pulled low and data may change;
- a rising-edge strobe, in the first counted high cycle;
- a mid-high strobe, marking the point at which data should be sampled.

The clock free-runs from the start request until the enable is removed. Some settings, stated as field values:
- Standard mode (100 kHz) uses 0xCF in both fields.
- Fast mode (400 kHz) uses 0x28 for the high phase and 0x3C for the low phase.

Top module: `i2c_scl_gen`

## Requirements
- R1: After reset, `scl_oe_o`, `fall_o`, `rise_o` and `mid_o` are all 0, and they stay 0 until a start request is accepted.
- R2: The low phase keeps `scl_oe_o` at 1 for exactly 2 + DIVL source cycles, where DIVL is `div_i[7:0]`.
- R3: The high phase counts exactly 2 + DIVH source cycles in which `scl_i` is 1, where DIVH is `div_i[15:8]`. With no stretching, falling edges are (2 + DIVH) + (2 + DIVL) source cycles apart.
- R4: While the block is idle, `en_i` is 1 and `start_i` is 1 at a clock edge, `scl_oe_o` and `fall_o` are 1 in the following cycle. `start_i` has no effect while the clock is running.
- R5: In the high phase, a cycle in which `scl_i` is 0 is not counted. `scl_oe_o` stays 0 through such cycles, so every stretched cycle lengthens the period by one.
- R6: `div_i` is captured only in the cycle a low phase begins. A change at any other time affects neither the phase in progress nor the following high phase.
- R7: When `en_i` is 0 at a clock edge, `scl_oe_o` is 0 from the next cycle. The counters return to idle, and a new start request is needed to resume.
- R8: `fall_o` is a one-cycle strobe in the first cycle of each low phase.
- R9: `rise_o` is a one-cycle strobe in the first high-phase cycle in which `scl_i` is 1.
- R10: `mid_o` is a one-cycle strobe in the high-phase cycle with counted index floor((2 + DIVH) / 2), where index 0 is the `rise_o` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable; 0 releases the line and idles the counters |
| div_i | input | 16 | Divider word: high-phase field in [15:8], low-phase field in [7:0] |
| start_i | input | 1 | Start request, honoured only while idle |
| scl_i | input | 1 | Sampled serial clock line level |
| scl_oe_o | output | 1 | Open-drain pull-down enable: 1 pulls the line low |
| fall_o | output | 1 | Strobe in the first cycle of a low phase |
| rise_o | output | 1 | Strobe in the first counted high cycle |
| mid_o | output | 1 | Strobe in the middle of the high phase |

## Verification
`scl_oe_o` and `fall_o` follow an accepted start or a phase change one clock later, because both come from the registered phase state. `rise_o` and `mid_o` also depend on the present value of `scl_i`, so they are due in the same cycle the line is seen high. The bench drives inputs at the falling edge and compares all four outputs, in that same half-cycle, against a behavioural model that is advanced once per rising edge. The model never looks at the design's internals. Period and low-time measurements are taken between observed `fall_o` strobes, so that stretching and divider changes are judged by their cycle counts at the ports.

// File: rtl/i2c_scl_pkg.sv
package i2c_scl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2
  } scl_state_e;

  localparam int unsigned PHASE_OFFSET = 2;
  localparam int unsigned NUM_PHASES   = 2;
endpackage

// File: rtl/i2c_scl_len.sv
// Phase-length registers; field g of div_i -> length g (0 = low, 1 = high).
module i2c_scl_len #(
  parameter int unsigned DIV_W = 8,
  localparam int unsigned LEN_W = DIV_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [2*DIV_W-1:0] div_i,
  output logic [LEN_W-1:0]   lo_len_o,
  output logic [LEN_W-1:0]   hi_len_o
);
  import i2c_scl_pkg::*;

  logic [LEN_W-1:0] len_q [NUM_PHASES];

  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_field
    logic [DIV_W-1:0] field;
    assign field = div_i[g*DIV_W +: DIV_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        len_q[g] <= LEN_W'(PHASE_OFFSET);
      end else if (load_i) begin
        len_q[g] <= {1'b0, field} + LEN_W'(PHASE_OFFSET);
      end
    end
  end

  assign lo_len_o = len_q[0];
  assign hi_len_o = len_q[1];
endmodule

// File: rtl/i2c_scl_ctr.sv
module i2c_scl_ctr #(
  parameter int unsigned LEN_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             zero_o,
  output logic             last_o,
  output logic             half_o
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (inc_i) begin
      cnt_q <= cnt_q + LEN_W'(1);
    end
  end

  assign zero_o = (cnt_q == '0);
  assign last_o = (cnt_q == len_i - LEN_W'(1));
  assign half_o = (cnt_q == (len_i >> 1));
endmodule

// File: rtl/i2c_scl_fsm.sv
module i2c_scl_fsm
  import i2c_scl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       start_i,
  input  logic       scl_i,
  input  logic       last_i,
  output scl_state_e state_o,
  output logic       load_o,
  output logic       clr_o,
  output logic       inc_o
);
  scl_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    clr_o   = 1'b0;
    inc_o   = 1'b0;
    if (!en_i) begin
      state_d = ST_IDLE;
      clr_o   = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          clr_o = 1'b1;
          if (start_i) begin
            state_d = ST_LOW;
            load_o  = 1'b1;
          end
        end
        ST_LOW: begin
          if (last_i) begin
            state_d = ST_HIGH;
            clr_o   = 1'b1;
          end else begin
            inc_o = 1'b1;
          end
        end
        ST_HIGH: begin
          // line held low by a slave: count frozen
          if (scl_i) begin
            if (last_i) begin
              state_d = ST_LOW;
              clr_o   = 1'b1;
              load_o  = 1'b1;
            end else begin
              inc_o = 1'b1;
            end
          end
        end
        default: begin
          state_d = ST_IDLE;
          clr_o   = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen #(
  parameter int unsigned DIV_W = 8,
  localparam int unsigned LEN_W = DIV_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [2*DIV_W-1:0] div_i,
  input  logic               start_i,
  input  logic               scl_i,
  output logic               scl_oe_o,
  output logic               fall_o,
  output logic               rise_o,
  output logic               mid_o
);
  import i2c_scl_pkg::*;

  scl_state_e       state_q;
  logic             load, clr, inc;
  logic             cnt_zero, cnt_last, cnt_half;
  logic [LEN_W-1:0] lo_len, hi_len, cur_len;

  i2c_scl_fsm i_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .start_i (start_i),
    .scl_i   (scl_i),
    .last_i  (cnt_last),
    .state_o (state_q),
    .load_o  (load),
    .clr_o   (clr),
    .inc_o   (inc)
  );

  i2c_scl_len #(.DIV_W(DIV_W)) i_len (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .div_i    (div_i),
    .lo_len_o (lo_len),
    .hi_len_o (hi_len)
  );

  assign cur_len = (state_q == ST_LOW) ? lo_len : hi_len;

  i2c_scl_ctr #(.LEN_W(LEN_W)) i_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .inc_i  (inc),
    .len_i  (cur_len),
    .zero_o (cnt_zero),
    .last_o (cnt_last),
    .half_o (cnt_half)
  );

  assign scl_oe_o = (state_q == ST_LOW);
  assign fall_o   = (state_q == ST_LOW) && cnt_zero;
  assign rise_o   = (state_q == ST_HIGH) && scl_i && cnt_zero;
  assign mid_o    = (state_q == ST_HIGH) && scl_i && cnt_half;
endmodule

// File: rtl/i2c_scl_gen_chk.sv
module i2c_scl_gen_chk
  import i2c_scl_pkg::*;
#(
  parameter int unsigned LEN_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             start_i,
  input logic             scl_i,
  input logic             scl_oe_o,
  input logic             fall_o,
  input logic             rise_o,
  input logic             mid_o,
  input scl_state_e       state_i,
  input logic [LEN_W-1:0] lo_len_i,
  input logic [LEN_W-1:0] hi_len_i
);
  p_strobe_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fall_o, rise_o, mid_o}));

  p_fall_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);

  p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!scl_oe_o && state_i == ST_IDLE));

  p_start_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE && en_i && start_i) |=> (scl_oe_o && fall_o));

  p_rise_line_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> (scl_i && !scl_oe_o));

  p_mid_line_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mid_o |-> (scl_i && !scl_oe_o));

  p_stretch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_HIGH && en_i && !scl_i) |=> (state_i == ST_HIGH && !scl_oe_o));

  p_len_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_LOW && !fall_o) |-> ($stable(lo_len_i) && $stable(hi_len_i)));
endmodule

bind i2c_scl_gen i2c_scl_gen_chk #(.LEN_W(LEN_W)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .en_i     (en_i),
  .start_i  (start_i),
  .scl_i    (scl_i),
  .scl_oe_o (scl_oe_o),
  .fall_o   (fall_o),
  .rise_o   (rise_o),
  .mid_o    (mid_o),
  .state_i  (state_q),
  .lo_len_i (lo_len),
  .hi_len_i (hi_len)
);

// File: tb/test_i2c_scl_gen.sv
module test_i2c_scl_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] div = 16'h0000;
  logic        start = 1'b0;
  logic        hold = 1'b0;
  logic        scl_line;
  logic        scl_oe, fall, rise, mid;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";

  always #5 clk = ~clk;

  // wired-AND bus: master pull-down or slave hold
  assign scl_line = ~scl_oe & ~hold;

  i2c_scl_gen i_i2c_scl_gen (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .en_i     (en),
    .div_i    (div),
    .start_i  (start),
    .scl_i    (scl_line),
    .scl_oe_o (scl_oe),
    .fall_o   (fall),
    .rise_o   (rise),
    .mid_o    (mid)
  );

  // behavioural reference: 0 idle, 1 low, 2 high
  int m_phase = 0, m_cnt = 0, m_lo = 2, m_hi = 2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_lo = 2; m_hi = 2;
    end else begin
      bit line;
      line = (m_phase != 1) && !hold;
      if (!en) begin
        m_phase = 0; m_cnt = 0;
      end else if (m_phase == 0) begin
        if (start) begin
          m_phase = 1; m_cnt = 0;
          m_lo = 2 + int'(div[7:0]); m_hi = 2 + int'(div[15:8]);
        end
      end else if (m_phase == 1) begin
        if (m_cnt == m_lo - 1) begin m_phase = 2; m_cnt = 0; end
        else m_cnt++;
      end else if (line) begin
        if (m_cnt == m_hi - 1) begin
          m_phase = 1; m_cnt = 0;
          m_lo = 2 + int'(div[7:0]); m_hi = 2 + int'(div[15:8]);
        end else m_cnt++;
      end
    end
  end

  int cyc = 0, last_fall = 0, last_period = 0, low_run = 0, last_low = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic compare();
    bit e_line, e_oe, e_fall, e_rise, e_mid;
    e_oe   = (m_phase == 1);
    e_line = !e_oe && !hold;
    e_fall = (m_phase == 1) && (m_cnt == 0);
    e_rise = (m_phase == 2) && e_line && (m_cnt == 0);
    e_mid  = (m_phase == 2) && e_line && (m_cnt == m_hi / 2);
    chk(scl_oe == e_oe, {cur_tag, " scl_oe_o"}, int'(scl_oe), int'(e_oe));
    chk(fall == e_fall, "R8 fall_o", int'(fall), int'(e_fall));
    chk(rise == e_rise, "R9 rise_o", int'(rise), int'(e_rise));
    chk(mid == e_mid, "R10 mid_o", int'(mid), int'(e_mid));
    cyc++;
    if (fall) begin
      last_period = cyc - last_fall;
      last_fall = cyc;
    end
    if (scl_oe) low_run++;
    else if (low_run != 0) begin
      last_low = low_run;
      low_run = 0;
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
    end
  endtask

  task automatic wait_fall();
    for (int i = 0; i < 2000; i++) begin
      tick(1);
      if (fall) return;
    end
  endtask

  task automatic wait_rise();
    for (int i = 0; i < 2000; i++) begin
      tick(1);
      if (rise) return;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(10 * 150000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  initial begin
    // R1: reset state, then idle while enabled without start
    tick(3);
    rst_n = 1'b1;
    tick(2);
    chk(!scl_oe && !fall && !rise && !mid, "R1 reset outputs", int'(scl_oe), 0);
    en = 1'b1;
    div = 16'h283C;
    tick(3);
    chk(!scl_oe, "R1 idle without start", int'(scl_oe), 0);

    // R4: start launches low phase next cycle
    cur_tag = "R4";
    start = 1'b1;
    tick(1);
    start = 1'b0;
    chk(scl_oe && fall, "R4 start to low", int'(scl_oe && fall), 1);
    tick(3);
    start = 1'b1;
    tick(2);
    start = 1'b0;

    // R2 / R3: fast mode timing
    cur_tag = "R3";
    wait_fall();
    wait_fall();
    chk(last_period == 104, "R3 fast period", last_period, 104);
    chk(last_low == 62, "R2 fast low time", last_low, 62);

    // R5: slave stretches high phase by 15 cycles
    cur_tag = "R5";
    wait_rise();
    hold = 1'b1;
    tick(15);
    chk(!scl_oe, "R5 no pull during stretch", int'(scl_oe), 0);
    hold = 1'b0;
    wait_fall();
    chk(last_period == 119, "R5 stretched period", last_period, 119);

    // R6: divider change mid low phase applies at next low start
    cur_tag = "R6";
    tick(5);
    div = 16'hCFCF;
    wait_fall();
    chk(last_period == 104, "R6 old divider kept", last_period, 104);
    wait_fall();
    chk(last_period == 418, "R3 standard period", last_period, 418);
    chk(last_low == 209, "R2 standard low time", last_low, 209);

    // R3 / R10: minimum setting
    cur_tag = "R10";
    div = 16'h0000;
    wait_fall();
    wait_fall();
    wait_fall();
    chk(last_period == 4, "R3 minimum period", last_period, 4);

    // R7: disable mid high phase
    cur_tag = "R7";
    div = 16'h0305;
    wait_fall();
    wait_rise();
    tick(1);
    en = 1'b0;
    tick(1);
    chk(!scl_oe && !fall && !rise && !mid, "R7 released", int'(scl_oe), 0);
    tick(5);
    en = 1'b1;
    tick(5);
    chk(!scl_oe, "R7 restart needs start", int'(scl_oe), 0);
    start = 1'b1;
    tick(1);
    start = 1'b0;
    chk(fall, "R7 restart", int'(fall), 1);
    wait_fall();
    chk(last_period == 12, "R7 period after restart", last_period, 12);
    tick(10);
    finish_run();
  end
endmodule